// File: doc/BRIEF.md
# Noise-Filtered Serial Control-Register Port

This block is a write-mostly serial slave that programs five control registers of a signal-conditioning front end. A host shifts in one 8-bit word, most significant bit first, while the active-low select is held low. The bit on the data input is captured on each rising edge of the serial clock. When the select returns high, the word is written into one of five registers. The leading bits of the word choose the register and the remaining bits are the data.

A strict framing filter protects the registers against glitches on the serial lines. A word is written only if three conditions hold: the serial clock was low when the select fell, exactly eight complete low-high-low clock pulses occurred while the select was low, and the clock was low again when the select rose. Any other sequence is dropped without side effects. The serial pins and the comparator input are brought into a faster system clock domain through synchronizers, and every edge is detected in that domain.

A diagnostic output mux drives the serial output. It can show a following copy of the serial data input, the comparator input, or a bit-serial readback of the prescaler register. When diagnostics are off, the output is held at zero.

Top module: `spi_filt_regif`

## Requirements
- R1: After reset all five register outputs read 0 and `so` is 0.
- R2: A well-framed word is decoded on its top bits: `00` writes bits [5:0] to `band_reg`, `01` writes bits [5:0] to `gain_reg`, `10` writes bits [5:0] to `integ_reg`, `110` writes bits [4:0] zero-extended to `presc_reg`, and `111` writes bits [4:0] zero-extended to `test_reg`. The word is sent MSB first and each bit is sampled on a rising `sck`.
- R3: If `sck` is high when `cs_n` falls, the word is discarded and every register keeps its value.
- R4: If the number of complete `sck` pulses while `cs_n` is low differs from eight (for example seven or nine), the word is discarded and every register keeps its value.
- R5: If `sck` is high when `cs_n` rises, the word is discarded and every register keeps its value.
- R6: A committed word changes only the register it addresses. No register changes at any other time.
- R7: The `test_reg` fields are: bit0 is the input channel select, bit1 is the diagnostic enable, bits[3:2] are the output source, and bit4 is the test-mode flag. When bit1 is 0, `so` is 0.
- R8: With diagnostics enabled and source `01`, `so` follows `si`.
- R9: With diagnostics enabled and source `10`, `so` follows `comp_in`.
- R10: With diagnostics enabled and source `00`, each transaction shifts out `presc_reg` zero-extended to 8 bits, MSB first, on `so`. The first bit is present after `cs_n` falls, and the next bit follows each falling `sck`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than `sck` |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low select that frames one word |
| si | input | 1 | Serial data input |
| comp_in | input | 1 | Comparator level for diagnostic output |
| so | output | 1 | Diagnostic serial output |
| band_reg | output | 6 | Bandpass frequency code |
| gain_reg | output | 6 | Gain / attenuation code |
| integ_reg | output | 6 | Integrator time-constant code |
| presc_reg | output | 6 | Prescaler / output status code (bit5 always 0) |
| test_reg | output | 6 | Channel, diagnostic and test control (bit5 always 0) |

## Verification
The properties assume that the serial pins move slowly compared with `clk`, so that every `sck` or `cs_n` level is held for several system cycles. Under that assumption each pin edge appears as exactly one synchronized edge, and a select edge never coincides with a clock edge in the synchronized domain. The stimulus keeps each `sck` half-period and each setup gap at eight system clocks. It also changes `si` and `comp_in` only in those gaps, and it separates every `cs_n` transition from every `sck` transition by at least that distance.

// File: rtl/spi_filt_pkg.sv
package spi_filt_pkg;
    // diagnostic output source codes held in test register bits [3:2]
    typedef enum logic [1:0] {
        SRC_READ = 2'b00,
        SRC_SI   = 2'b01,
        SRC_COMP = 2'b10,
        SRC_OFF  = 2'b11
    } so_src_e;

    localparam int TST_CHAN   = 0;
    localparam int TST_DIAG   = 1;
    localparam int TST_SRC_LO = 2;
    localparam int TST_MODE   = 4;
endpackage

// File: rtl/spi_filt_sync.sv
module spi_filt_sync #(
    parameter int           W      = 4,
    parameter int           STAGES = 2,
    parameter logic [W-1:0] RST    = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe_q [STAGES];
    logic [W-1:0] pipe_d [STAGES];

    always_comb begin
        pipe_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe_q[i] <= RST;
        end else begin
            for (int i = 0; i < STAGES; i++) pipe_q[i] <= pipe_d[i];
        end
    end

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/spi_filt_frame.sv
module spi_filt_frame #(
    parameter int WORD_W = 8,
    localparam int CNT_W = $clog2(WORD_W + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_s,
    input  logic              csn_s,
    input  logic              si_s,
    output logic              commit,
    output logic [WORD_W-1:0] word,
    output logic              cs_fall,
    output logic              sck_fall
);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(WORD_W + 1);
    localparam logic [CNT_W-1:0] CNT_GOOD = CNT_W'(WORD_W);

    typedef struct packed {
        logic              sck_p;
        logic              csn_p;
        logic              active;
        logic              bad;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] shreg;
        logic              commit;
    } frame_t;

    frame_t st_d, st_q;
    logic cs_rise, sck_rise;

    assign cs_fall  =  st_q.csn_p & ~csn_s;
    assign cs_rise  = ~st_q.csn_p &  csn_s;
    assign sck_rise = ~st_q.sck_p &  sck_s;
    assign sck_fall =  st_q.sck_p & ~sck_s;

    always_comb begin
        st_d        = st_q;
        st_d.sck_p  = sck_s;
        st_d.csn_p  = csn_s;
        st_d.commit = 1'b0;
        if (cs_fall) begin
            st_d.active = 1'b1;
            st_d.bad    = sck_s;
            st_d.cnt    = '0;
        end else if (st_q.active) begin
            if (cs_rise) begin
                st_d.active = 1'b0;
                st_d.commit = ~st_q.bad & (st_q.cnt == CNT_GOOD) & ~sck_s;
            end else begin
                if (sck_rise) st_d.shreg = {st_q.shreg[WORD_W-2:0], si_s};
                if (sck_fall && st_q.cnt != CNT_MAX) st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.csn_p <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign commit = st_q.commit;
    assign word   = st_q.shreg;
endmodule

// File: rtl/spi_filt_regbank.sv
module spi_filt_regbank #(
    parameter int WORD_W = 8,
    localparam int DATA_W = WORD_W - 2,
    localparam int SUB_W  = DATA_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [WORD_W-1:0] word,
    output logic [DATA_W-1:0] band,
    output logic [DATA_W-1:0] gain,
    output logic [DATA_W-1:0] integ,
    output logic [DATA_W-1:0] presc,
    output logic [DATA_W-1:0] test
);
    typedef struct packed {
        logic [DATA_W-1:0] band;
        logic [DATA_W-1:0] gain;
        logic [DATA_W-1:0] integ;
        logic [DATA_W-1:0] presc;
        logic [DATA_W-1:0] test;
    } bank_t;

    bank_t bk_d, bk_q;

    always_comb begin
        bk_d = bk_q;
        if (commit) begin
            unique case (word[WORD_W-1 -: 2])
                2'b00: bk_d.band  = word[DATA_W-1:0];
                2'b01: bk_d.gain  = word[DATA_W-1:0];
                2'b10: bk_d.integ = word[DATA_W-1:0];
                default: begin
                    if (word[DATA_W-1]) bk_d.test  = {1'b0, word[SUB_W-1:0]};
                    else                bk_d.presc = {1'b0, word[SUB_W-1:0]};
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bk_q <= '0;
        else        bk_q <= bk_d;
    end

    assign band  = bk_q.band;
    assign gain  = bk_q.gain;
    assign integ = bk_q.integ;
    assign presc = bk_q.presc;
    assign test  = bk_q.test;
endmodule

// File: rtl/spi_filt_somux.sv
module spi_filt_somux
    import spi_filt_pkg::*;
#(
    parameter int WORD_W = 8,
    localparam int DATA_W = WORD_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] test,
    input  logic [DATA_W-1:0] presc,
    input  logic              si_s,
    input  logic              comp_s,
    input  logic              cs_fall,
    input  logic              sck_fall,
    output logic              so
);
    typedef struct packed {
        logic [WORD_W-1:0] rdsh;
        logic              so;
    } mux_t;

    mux_t mx_d, mx_q;
    so_src_e src;

    assign src = so_src_e'(test[TST_SRC_LO +: 2]);

    always_comb begin
        mx_d = mx_q;
        if (cs_fall)       mx_d.rdsh = WORD_W'(presc);
        else if (sck_fall) mx_d.rdsh = {mx_q.rdsh[WORD_W-2:0], 1'b0};
        mx_d.so = 1'b0;
        if (test[TST_DIAG]) begin
            unique case (src)
                SRC_READ: mx_d.so = mx_q.rdsh[WORD_W-1];
                SRC_SI:   mx_d.so = si_s;
                SRC_COMP: mx_d.so = comp_s;
                default:  mx_d.so = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mx_q <= '0;
        else        mx_q <= mx_d;
    end

    assign so = mx_q.so;
endmodule

// File: rtl/spi_filt_regif.sv
module spi_filt_regif #(
    parameter int WORD_W      = 8,
    parameter int SYNC_STAGES = 2,
    localparam int DATA_W     = WORD_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              si,
    input  logic              comp_in,
    output logic              so,
    output logic [DATA_W-1:0] band_reg,
    output logic [DATA_W-1:0] gain_reg,
    output logic [DATA_W-1:0] integ_reg,
    output logic [DATA_W-1:0] presc_reg,
    output logic [DATA_W-1:0] test_reg
);
    logic [3:0]        pins_s;
    logic              sck_s, csn_s, si_s, comp_s;
    logic              commit, cs_fall, sck_fall;
    logic [WORD_W-1:0] word;

    spi_filt_sync #(.W(4), .STAGES(SYNC_STAGES), .RST(4'b0010)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({comp_in, si, cs_n, sck}),
        .q(pins_s)
    );
    assign {comp_s, si_s, csn_s, sck_s} = pins_s;

    spi_filt_frame #(.WORD_W(WORD_W)) u_frame (
        .clk(clk), .rst_n(rst_n),
        .sck_s(sck_s), .csn_s(csn_s), .si_s(si_s),
        .commit(commit), .word(word),
        .cs_fall(cs_fall), .sck_fall(sck_fall)
    );

    spi_filt_regbank #(.WORD_W(WORD_W)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .commit(commit), .word(word),
        .band(band_reg), .gain(gain_reg), .integ(integ_reg),
        .presc(presc_reg), .test(test_reg)
    );

    spi_filt_somux #(.WORD_W(WORD_W)) u_somux (
        .clk(clk), .rst_n(rst_n),
        .test(test_reg), .presc(presc_reg),
        .si_s(si_s), .comp_s(comp_s),
        .cs_fall(cs_fall), .sck_fall(sck_fall),
        .so(so)
    );
endmodule

// File: rtl/spi_filt_regif_chk.sv
module spi_filt_regif_chk
    import spi_filt_pkg::*;
#(
    parameter int DATA_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              commit,
    input logic              csn_s,
    input logic              sck_s,
    input logic              so,
    input logic [DATA_W-1:0] band_reg,
    input logic [DATA_W-1:0] gain_reg,
    input logic [DATA_W-1:0] integ_reg,
    input logic [DATA_W-1:0] presc_reg,
    input logic [DATA_W-1:0] test_reg
);
    logic [5*DATA_W-1:0] all_regs;
    assign all_regs = {band_reg, gain_reg, integ_reg, presc_reg, test_reg};

    a_r6_hold_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(all_regs));

    a_r6_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({band_reg  != $past(band_reg),
                    gain_reg  != $past(gain_reg),
                    integ_reg != $past(integ_reg),
                    presc_reg != $past(presc_reg),
                    test_reg  != $past(test_reg)}) <= 1);

    a_r5_no_commit_sck_high: assert property (@(posedge clk) disable iff (!rst_n)
        (csn_s && !$past(csn_s) && sck_s) |=> !commit);

    a_r7_so_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !test_reg[TST_DIAG] |=> !so);

    a_r2_commit_single: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);
endmodule

bind spi_filt_regif spi_filt_regif_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .commit(commit),
    .csn_s(csn_s), .sck_s(sck_s), .so(so),
    .band_reg(band_reg), .gain_reg(gain_reg), .integ_reg(integ_reg),
    .presc_reg(presc_reg), .test_reg(test_reg)
);

// File: tb/spi_filt_regif_tb.sv
module spi_filt_regif_tb;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, comp_in = 1'b0;
    logic so;
    logic [5:0] band_reg, gain_reg, integ_reg, presc_reg, test_reg;

    int checks = 0;
    int errors = 0;
    bit settled = 1'b0;
    bit done = 1'b0;
    logic si_idle = 1'b0;
    logic [5:0] exp_r [5];
    logic [7:0] rd;

    always #10 clk = ~clk;

    spi_filt_regif u_dut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
        .comp_in(comp_in), .so(so),
        .band_reg(band_reg), .gain_reg(gain_reg), .integ_reg(integ_reg),
        .presc_reg(presc_reg), .test_reg(test_reg)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic exp_so();
        if (!exp_r[4][1]) return 1'b0;
        case (exp_r[4][3:2])
            2'b01:   return si_idle;
            2'b10:   return comp_in;
            default: return 1'b0;
        endcase
    endfunction

    // model of the register bank: address in the top bits
    task automatic model_write(input logic [7:0] w);
        case (w[7:6])
            2'b00: exp_r[0] = w[5:0];
            2'b01: exp_r[1] = w[5:0];
            2'b10: exp_r[2] = w[5:0];
            default: if (w[5]) exp_r[4] = {1'b0, w[4:0]};
                     else      exp_r[3] = {1'b0, w[4:0]};
        endcase
    endtask

    task automatic chk_regs(input string req);
        chk({req, " band"},  int'(band_reg),  int'(exp_r[0]));
        chk({req, " gain"},  int'(gain_reg),  int'(exp_r[1]));
        chk({req, " integ"}, int'(integ_reg), int'(exp_r[2]));
        chk({req, " presc"}, int'(presc_reg), int'(exp_r[3]));
        chk({req, " test"},  int'(test_reg),  int'(exp_r[4]));
    endtask

    task automatic xfer(input logic [7:0] w, input int npulse,
                        input bit hi_fall, input bit hi_rise,
                        output logic [7:0] rdo);
        settled = 1'b0;
        rdo = '0;
        sck = hi_fall;
        wait_clk(HALF);
        cs_n = 1'b0;
        wait_clk(HALF);
        if (hi_fall) begin sck = 1'b0; wait_clk(HALF); end
        for (int i = 0; i < npulse; i++) begin
            si = (i < 8) ? w[7-i] : 1'b0;
            wait_clk(HALF);
            if (i < 8) rdo[7-i] = so;
            sck = 1'b1;
            wait_clk(HALF);
            sck = 1'b0;
        end
        wait_clk(HALF);
        if (hi_rise) begin sck = 1'b1; wait_clk(HALF); end
        cs_n = 1'b1;
        wait_clk(HALF);
        sck = 1'b0;
        si = si_idle;
        wait_clk(HALF);
        if (!hi_fall && !hi_rise && npulse == 8) model_write(w);
        settled = 1'b1;
    endtask

    task automatic set_level(input logic s, input logic c);
        settled = 1'b0;
        si_idle = s; si = s; comp_in = c;
        wait_clk(HALF);
        settled = 1'b1;
    endtask

    // per-clock comparison against the model while the lines are quiet
    always @(posedge clk) begin
        #5;
        if (settled && rst_n && !done) begin
            chk_regs("R6 monitor");
            if (exp_r[4][3:2] != 2'b00 || !exp_r[4][1])
                chk("R7/R8/R9 monitor so", int'(so), int'(exp_so()));
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 5; i++) exp_r[i] = '0;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(4);
        chk_regs("R1 reset");
        chk("R1 reset so", int'(so), 0);
        settled = 1'b1;

        // R2: each address code
        xfer(8'h2A, 8, 0, 0, rd); chk_regs("R2 band write");
        xfer(8'h73, 8, 0, 0, rd); chk_regs("R2 gain write");
        xfer(8'h87, 8, 0, 0, rd); chk_regs("R2 integ write");
        xfer(8'hD6, 8, 0, 0, rd); chk_regs("R2 presc write");
        xfer(8'hE1, 8, 0, 0, rd); chk_regs("R2 test write channel bit");
        chk("R6 band kept", int'(band_reg), 6'h2A);
        xfer(8'h4C, 8, 0, 0, rd); chk("R2 gain overwrite", int'(gain_reg), 6'h0C);

        // rejected frames
        xfer(8'h15, 7, 0, 0, rd); chk_regs("R4 seven pulses");
        chk("R4 band unchanged 7", int'(band_reg), 6'h2A);
        xfer(8'h15, 9, 0, 0, rd); chk_regs("R4 nine pulses");
        chk("R4 band unchanged 9", int'(band_reg), 6'h2A);
        xfer(8'h15, 8, 1, 0, rd); chk_regs("R3 sck high at fall");
        chk("R3 band unchanged", int'(band_reg), 6'h2A);
        xfer(8'h15, 8, 0, 1, rd); chk_regs("R5 sck high at rise");
        chk("R5 band unchanged", int'(band_reg), 6'h2A);

        // R8: so follows si
        xfer(8'hE6, 8, 0, 0, rd); chk("R8 test reg", int'(test_reg), 6'h06);
        set_level(1'b1, 1'b0); chk("R8 so high", int'(so), 1);
        set_level(1'b0, 1'b1); chk("R8 so low", int'(so), 0);

        // R9: so follows comparator
        xfer(8'hEA, 8, 0, 0, rd); chk("R9 test reg", int'(test_reg), 6'h0A);
        set_level(1'b0, 1'b1); chk("R9 so high", int'(so), 1);
        set_level(1'b1, 1'b0); chk("R9 so low", int'(so), 0);
        set_level(1'b0, 1'b0);

        // R10: prescaler readback
        xfer(8'hE2, 8, 0, 0, rd); chk("R10 test reg", int'(test_reg), 6'h02);
        xfer(8'h05, 8, 0, 0, rd); chk("R10 readback", int'(rd), 8'h16);
        chk("R2 band after readback", int'(band_reg), 6'h05);
        xfer(8'hC9, 8, 0, 0, rd); chk("R10 presc new", int'(presc_reg), 6'h09);
        xfer(8'h00, 8, 0, 0, rd); chk("R10 readback new", int'(rd), 8'h09);

        // R7: diagnostics off
        xfer(8'hF4, 8, 0, 0, rd); chk("R7 test reg", int'(test_reg), 6'h14);
        set_level(1'b1, 1'b1); chk("R7 so quiet", int'(so), 0);
        xfer(8'h3F, 8, 0, 0, rd); chk("R7 readback off", int'(rd), 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule